// File: doc/BRIEF.md
# Padded Vertex Count Generator

This block turns an unsigned vertex count into a padded dispatch count that a thread dispatcher can split cheaply into a quotient and a remainder. Every padded value is an odd factor of 1, 3, 5, 7 or 9 times a power of two, so a divide or modulo by it reduces to a small fixed odd divider and a shift. The block also gives the padded value in encoded form: a shift exponent and a 3-bit odd selector equal to (odd - 1) / 2.

Counts of 32 and above are padded from their leading one and the three bits below it. If those four bits hold the value h and n bits lie below them, the result is the smallest of 9, 10, 12, 14 or 16 times 2^n that is strictly above h times 2^n. Smaller counts round up to the next multiple of four strictly above the count. The padded result is one bit wider than the count, so an all-ones count can reach 2^CNT_W. For the same reason the shift output has $clog2(CNT_W+1) bits, which is 6 bits at the default width.

A valid strobe is taken with each count. In the default variant the result appears one clock later under an output valid.

Top module: `pvc_pad_gen`

## Requirements
- R1: Every padded count is strictly greater than the count it was computed from.
- R2: Every padded count is a multiple of four, so bits [1:0] are zero.
- R3: The odd selector is at most 4, and the padded count equals (2*odd+1) shifted left by the shift output.
- R4: A count c below 32 gives 4*(floor(c/4)+1).
- R5: For a count of 32 or more, let h be the leading one plus the three bits below it, and n the number of lower bits. The result is 9*2^n for h=8, 10*2^n for h=9, 12*2^n for h=10 or 11, 14*2^n for h=12 or 13, and 16*2^n for h=14 or 15.
- R6: A count of 70 gives a padded count of 72, with odd selector 4 and shift 3.
- R7: A count of zero gives a padded count of 4, with odd selector 0 and shift 2.
- R8: With REGISTERED=1, out_vld is high exactly one cycle after in_vld was high. The outputs hold their value in any cycle after one in which in_vld was low.
- R9: While rst_n is low, out_vld and all result outputs are zero.
- R10: An all-ones count gives a padded count of 2^CNT_W, with odd selector 0 and shift CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Count strobe |
| in_count | input | CNT_W | Unsigned vertex count |
| out_vld | output | 1 | Result strobe |
| out_padded | output | CNT_W+1 | Padded dispatch count |
| out_shift | output | $clog2(CNT_W+1) | Power-of-two exponent of the padded count |
| out_odd | output | 3 | Odd factor selector, (odd-1)/2 |

## Verification
The assertions assume that in_vld is held low during reset, so the first comparison against a past count always refers to a count captured after reset. They also assume that in_count is a known value whenever in_vld is high. The stimulus satisfies both by driving in_vld to zero throughout reset and by always pairing the strobe with a fully defined count. Inputs change only on the falling clock edge.

The stimulus covers three groups of counts:
- every count from 0 to 4095;
- for each leading-one position from 12 to 31, all eight values of the four top bits, each combined with zero, all-ones and alternating lower bits;
- the all-ones count.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
   // Counts below 2**SMALL_BITS take the multiple-of-four path.
   localparam int unsigned SMALL_BITS = 5;
   // Leading one plus the three bits below it pick the bucket.
   localparam int unsigned HIGH_BITS  = 4;
   localparam int unsigned ODD_W      = 3;
   localparam int unsigned ADJ_W      = 3;
   localparam int unsigned MULT_W     = 5;

   typedef struct packed {
      logic [ODD_W-1:0]  odd;   // (odd factor - 1) / 2
      logic [ADJ_W-1:0]  adj;   // extra exponent after normalising
      logic [MULT_W-1:0] mult;  // multiplier applied to 2^n
   } bucket_t;
endpackage

// File: rtl/pvc_lead_one.sv
module pvc_lead_one #(
   parameter int unsigned W  = 32,
   parameter int unsigned PW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [PW-1:0] pos,
   output logic          found
);
   // Ascending scan: the last set bit seen is the most significant one.
   always_comb begin
      pos   = '0;
      found = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) begin
            pos   = PW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/pvc_bucket.sv
module pvc_bucket
   import pvc_pkg::*;
(
   input  logic [HIGH_BITS-1:0] hi,
   output bucket_t              bkt
);
   always_comb begin
      unique case (hi)
         4'b1000:          bkt = '{odd: 3'd4, adj: 3'd0, mult: 5'd9};   // 9
         4'b1001:          bkt = '{odd: 3'd2, adj: 3'd1, mult: 5'd10};  // 5*2
         4'b1010, 4'b1011: bkt = '{odd: 3'd1, adj: 3'd2, mult: 5'd12};  // 3*4
         4'b1100, 4'b1101: bkt = '{odd: 3'd3, adj: 3'd1, mult: 5'd14};  // 7*2
         default:          bkt = '{odd: 3'd0, adj: 3'd4, mult: 5'd16};  // 1*16
      endcase
   end
endmodule

// File: rtl/pvc_small.sv
module pvc_small
   import pvc_pkg::*;
#(
   parameter int unsigned PAD_W = 33,
   parameter int unsigned SH_W  = 6
) (
   input  logic [SMALL_BITS-1:0] cnt,
   output logic [PAD_W-1:0]      padded,
   output logic [ODD_W-1:0]      odd,
   output logic [SH_W-1:0]       shift
);
   logic [3:0] quads;   // number of groups of four, 1..8
   logic [1:0] tz;
   logic [3:0] odd_full;

   assign quads  = {1'b0, cnt[SMALL_BITS-1:2]} + 4'd1;
   assign padded = PAD_W'(quads) << 2;

   always_comb begin
      if (quads[0])      tz = 2'd0;
      else if (quads[1]) tz = 2'd1;
      else if (quads[2]) tz = 2'd2;
      else               tz = 2'd3;
   end

   assign odd_full = quads >> tz;
   assign odd      = odd_full[ODD_W:1];
   assign shift    = SH_W'(tz) + SH_W'(2);
endmodule

// File: rtl/pvc_pad_gen.sv
module pvc_pad_gen
   import pvc_pkg::*;
#(
   parameter int unsigned CNT_W      = 32,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_vld,
   input  logic [CNT_W-1:0]             in_count,
   output logic                         out_vld,
   output logic [CNT_W:0]               out_padded,
   output logic [$clog2(CNT_W+1)-1:0]   out_shift,
   output logic [2:0]                   out_odd
);
   localparam int unsigned PAD_W = CNT_W + 1;
   localparam int unsigned SH_W  = $clog2(CNT_W + 1);
   localparam int unsigned PW    = $clog2(CNT_W);

   if (CNT_W < SMALL_BITS + 1 || CNT_W > 63) begin : g_bad_width
      $error("pvc_pad_gen: CNT_W must lie in 6..63");
   end

   // Leading-one search
   logic [PW-1:0] lead_pos;
   logic          lead_found;

   pvc_lead_one #(.W(CNT_W), .PW(PW)) i_lead (
      .vec   (in_count),
      .pos   (lead_pos),
      .found (lead_found)
   );

   // Large-count path
   logic [SH_W-1:0]      n_exp;
   logic [CNT_W-1:0]     aligned;
   logic [HIGH_BITS-1:0] hi_bits;
   bucket_t              bkt;
   logic [PAD_W-1:0]     big_padded;
   logic [SH_W-1:0]      big_shift;

   assign n_exp   = SH_W'(lead_pos) - SH_W'(HIGH_BITS - 1);
   assign aligned = in_count >> n_exp;
   assign hi_bits = aligned[HIGH_BITS-1:0];

   pvc_bucket i_bucket (
      .hi  (hi_bits),
      .bkt (bkt)
   );

   assign big_padded = PAD_W'(bkt.mult) << n_exp;
   assign big_shift  = n_exp + SH_W'(bkt.adj);

   // Small-count path
   logic [PAD_W-1:0] sml_padded;
   logic [ODD_W-1:0] sml_odd;
   logic [SH_W-1:0]  sml_shift;

   pvc_small #(.PAD_W(PAD_W), .SH_W(SH_W)) i_small (
      .cnt    (in_count[SMALL_BITS-1:0]),
      .padded (sml_padded),
      .odd    (sml_odd),
      .shift  (sml_shift)
   );

   // Path select
   logic             is_small;
   logic [PAD_W-1:0] nxt_padded;
   logic [ODD_W-1:0] nxt_odd;
   logic [SH_W-1:0]  nxt_shift;

   assign is_small   = !lead_found || (lead_pos < PW'(SMALL_BITS));
   assign nxt_padded = is_small ? sml_padded : big_padded;
   assign nxt_odd    = is_small ? sml_odd    : bkt.odd;
   assign nxt_shift  = is_small ? sml_shift  : big_shift;

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_vld    <= 1'b0;
            out_padded <= '0;
            out_odd    <= '0;
            out_shift  <= '0;
         end else begin
            out_vld <= in_vld;
            if (in_vld) begin
               out_padded <= nxt_padded;
               out_odd    <= nxt_odd;
               out_shift  <= nxt_shift;
            end
         end
      end

      AST_ABOVE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> (out_padded > PAD_W'($past(in_count)))); // R1
      AST_MULT_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld |-> (out_padded[1:0] == 2'b00)); // R2
      AST_ODD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld |-> (out_odd <= 3'd4)); // R3
      AST_ENCODE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
         out_vld |-> (out_padded == (PAD_W'({out_odd, 1'b1}) << out_shift))); // R3
      AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
         in_vld |=> out_vld); // R8
      AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> !out_vld); // R8
      AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
         !in_vld |=> ($stable(out_padded) && $stable(out_shift) && $stable(out_odd))); // R8
   end else begin : g_comb
      assign out_vld    = in_vld;
      assign out_padded = nxt_padded;
      assign out_odd    = nxt_odd;
      assign out_shift  = nxt_shift;
   end
endmodule

// File: tb/test_pvc_pad_gen.sv
module test_pvc_pad_gen;
   localparam int unsigned CNT_W = 32;
   localparam int unsigned SH_W  = $clog2(CNT_W + 1);

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               in_vld = 1'b0;
   logic [CNT_W-1:0]   in_count = '0;
   logic               out_vld;
   logic [CNT_W:0]     out_padded;
   logic [SH_W-1:0]    out_shift;
   logic [2:0]         out_odd;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pvc_pad_gen #(.CNT_W(CNT_W), .REGISTERED(1'b1)) i_pvc_pad_gen (
      .clk, .rst_n, .in_vld, .in_count,
      .out_vld, .out_padded, .out_shift, .out_odd
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Smallest value of form odd*2^k (odd in 1,3,5,7,9, k>=2) strictly above c.
   function automatic logic [63:0] ref_pad(input logic [63:0] c);
      logic [63:0] best = 64'hFFFF_FFFF_FFFF_FFFF;
      for (int k = 2; k <= CNT_W + 1; k++) begin
         for (int o = 1; o <= 9; o += 2) begin
            logic [63:0] v = 64'(o) << k;
            if (v > c && v < best) best = v;
         end
      end
      return best;
   endfunction

   task automatic apply(input logic [CNT_W-1:0] c);
      @(negedge clk);
      in_vld   = 1'b1;
      in_count = c;
      @(negedge clk);
      in_vld   = 1'b0;
   endtask

   task automatic check_vec(input logic [CNT_W-1:0] c);
      logic [63:0] exp = ref_pad(64'(c));
      logic [63:0] act = 64'(out_padded);
      logic [63:0] enc = 64'({out_odd, 1'b1}) << out_shift;
      chk(out_vld == 1'b1, "R8 valid", 64'(out_vld), 64'd1);
      if (c < 32) chk(act == exp, "R4 small count", act, exp);
      else        chk(act == exp, "R5 bucket", act, exp);
      chk(act > 64'(c), "R1 above input", act, 64'(c) + 64'd1);
      chk(act[1:0] == 2'b00, "R2 multiple of four", act, exp);
      chk(out_odd <= 3'd4 && enc == act, "R3 encoding", enc, act);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(out_vld == 1'b0, "R9 reset valid", 64'(out_vld), 64'd0);
      chk(out_padded == '0 && out_odd == '0 && out_shift == '0, "R9 reset outputs",
          64'(out_padded), 64'd0);
      rst_n = 1'b1;

      // R7 zero count
      apply('0);
      chk(out_padded == 33'd4 && out_odd == 3'd0 && out_shift == 6'd2, "R7 zero",
          {out_padded, out_odd, out_shift}, {33'd4, 3'd0, 6'd2});
      // R8 outputs hold and valid drops when idle
      @(negedge clk);
      chk(out_vld == 1'b0, "R8 valid drop", 64'(out_vld), 64'd0);
      chk(out_padded == 33'd4, "R8 hold", 64'(out_padded), 64'd4);

      // R6 worked example
      apply(32'd70);
      chk(out_padded == 33'd72 && out_odd == 3'd4 && out_shift == 6'd3, "R6 seventy",
          {out_padded, out_odd, out_shift}, {33'd72, 3'd4, 6'd3});

      // R10 all-ones count
      apply('1);
      chk(out_padded == {1'b1, 32'd0} && out_odd == 3'd0 && out_shift == 6'(CNT_W), "R10 max",
          {out_padded, out_odd, out_shift}, {1'b1, 32'd0, 3'd0, 6'(CNT_W)});

      // Exhaustive low range (R4, R5)
      for (int c = 0; c < 4096; c++) begin
         apply(CNT_W'(c));
         check_vec(CNT_W'(c));
      end

      // Every bucket at every high leading-one position (R5)
      for (int b = 12; b < CNT_W; b++) begin
         for (int h = 8; h < 16; h++) begin
            for (int p = 0; p < 3; p++) begin
               logic [63:0] mask = (64'd1 << (b - 3)) - 64'd1;
               logic [63:0] low  = (p == 0) ? 64'd0 : (p == 1) ? mask : (64'h5555_5555_5555_5555 & mask);
               logic [CNT_W-1:0] c = CNT_W'((64'(h) << (b - 3)) | low);
               apply(c);
               check_vec(c);
            end
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 64'd0, 64'd1);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end
endmodule